// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

The sequencer expands one prefixed scalar operation into a stream of per-element issues. It takes a vector length, a predicate mask for the source side and another for the destination side, an element-width code and three mode flags: reverse traversal, saturation and data-dependent fail-first. It then hands out one source/destination element pair per accepted handshake. The arithmetic unit that consumes the issues returns a condition bit on the same handshake. In fail-first mode that bit can end the loop early.

Each side has its own mask, and each side skips its own masked-off elements. The k-th issue pairs the k-th live source element with the k-th live destination element. The result behaves like a gather feeding a scatter. Each mask is picked from an integer-register image or a condition-field image by a select bit. Element indices are added to a base register number, and the block never issues an element whose register number would leave the 128-entry file. When the loop ends, the block pulses done for one cycle and reports how many elements it committed.

Top module: `vec_elem_seq`

## Requirements
- R1: In forward mode the issues come in ascending element order, and every issue pairs the k-th live source element with the k-th live destination element.
- R2: Source and destination masks act independently. Each index skips only the clear bits of its own mask, and the loop ends when either side has no live element left.
- R3: When reverse is set, both indices walk from the highest live element down to the lowest.
- R4: With fail-first set, a handshake whose cond_ok_i is low ends the loop. That element is not counted, done_o rises in the following cycle, and done_vl_o equals the number of elements accepted before it.
- R5: ew_o carries the width code captured at start with every issue: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = 64 bit.
- R6: sat_o carries the saturation flag captured at start with every issue.
- R7: A select input of 1 takes that side's mask from its condition-field image; a select input of 0 takes it from its integer-register image. Bit i of a mask enables element i.
- R8: src_reg_o and dst_reg_o equal the captured base plus the element index. An element whose register number would exceed 127 is never issued.
- R9: A vector length of zero, or a side with no live element, gives no issue, and done_o is high in the cycle after the start edge.
- R10: While issue_valid_o is high and issue_ready_i is low, all issue outputs hold their values.
- R11: done_o is high for exactly one cycle per operation. done_vl_o at that time equals the number of committed elements, and issue_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins an operation when idle |
| vl_i | input | CW | Vector length |
| src_mask_int_i | input | MAX_VL | Source mask, integer-register image |
| src_mask_cr_i | input | MAX_VL | Source mask, condition-field image |
| src_mask_sel_i | input | 1 | Source mask select, 1 = condition fields |
| dst_mask_int_i | input | MAX_VL | Destination mask, integer-register image |
| dst_mask_cr_i | input | MAX_VL | Destination mask, condition-field image |
| dst_mask_sel_i | input | 1 | Destination mask select, 1 = condition fields |
| src_base_i | input | RW | Source base register number |
| dst_base_i | input | RW | Destination base register number |
| ew_i | input | 2 | Element-width code |
| reverse_i | input | 1 | Reverse traversal |
| sat_i | input | 1 | Saturation mode |
| ffirst_i | input | 1 | Data-dependent fail-first |
| issue_valid_o | output | 1 | An element issue is offered |
| issue_ready_i | input | 1 | Consumer accepts the issue |
| src_idx_o | output | IW | Source element index |
| dst_idx_o | output | IW | Destination element index |
| src_reg_o | output | RW | Source register number |
| dst_reg_o | output | RW | Destination register number |
| ew_o | output | 2 | Element-width code |
| sat_o | output | 1 | Saturate flag |
| cond_ok_i | input | 1 | Condition result of the accepted element |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| done_vl_o | output | CW | Committed element count |

## Verification
The bench builds the block with MAX_VL = 16 and the default 128-entry register file. A 16-element mask is small enough to compute every expected index pair by hand, and a base of 124 with a length of 8 hits the register-file ceiling partway through a loop. Ready patterns with gaps test the hold behaviour. Each case drives the unused mask image with the complement of the selected one, so a wrong select shows up as wrong indices.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } elem_width_e;
endpackage

// File: rtl/vseq_mask_prep.sv
// Selects the mask image and clears elements beyond vl or beyond the register file.
module vseq_mask_prep #(
  parameter int unsigned MAX_VL    = 64,
  parameter int unsigned REG_COUNT = 128,
  localparam int unsigned CW = $clog2(MAX_VL + 1),
  localparam int unsigned RW = $clog2(REG_COUNT)
) (
  input  logic [MAX_VL-1:0] int_mask_i,
  input  logic [MAX_VL-1:0] cr_mask_i,
  input  logic              sel_i,
  input  logic [CW-1:0]     vl_i,
  input  logic [RW-1:0]     base_i,
  output logic [MAX_VL-1:0] live_o
);
  logic [MAX_VL-1:0] picked;
  assign picked = sel_i ? cr_mask_i : int_mask_i;

  for (genvar i = 0; i < MAX_VL; i++) begin : g_bit
    localparam int unsigned IDX = i;
    logic in_len, in_file;
    assign in_len  = IDX < 32'(vl_i);
    assign in_file = (IDX + 32'(base_i)) < REG_COUNT;
    assign live_o[i] = picked[i] & in_len & in_file;
  end
endmodule

// File: rtl/vseq_pick.sv
// Lowest set bit in forward mode, highest in reverse mode.
module vseq_pick #(
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned IW = $clog2(MAX_VL)
) (
  input  logic [MAX_VL-1:0] live_i,
  input  logic              rev_i,
  output logic              found_o,
  output logic [IW-1:0]     idx_o
);
  always_comb begin
    found_o = |live_i;
    idx_o   = '0;
    if (rev_i) begin
      for (int i = 0; i < MAX_VL; i++)
        if (live_i[i]) idx_o = IW'(i);
    end else begin
      for (int i = MAX_VL - 1; i >= 0; i--)
        if (live_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int unsigned MAX_VL    = 64,
  parameter int unsigned REG_COUNT = 128,
  localparam int unsigned IW = $clog2(MAX_VL),
  localparam int unsigned CW = $clog2(MAX_VL + 1),
  localparam int unsigned RW = $clog2(REG_COUNT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CW-1:0]     vl_i,
  input  logic [MAX_VL-1:0] src_mask_int_i,
  input  logic [MAX_VL-1:0] src_mask_cr_i,
  input  logic              src_mask_sel_i,
  input  logic [MAX_VL-1:0] dst_mask_int_i,
  input  logic [MAX_VL-1:0] dst_mask_cr_i,
  input  logic              dst_mask_sel_i,
  input  logic [RW-1:0]     src_base_i,
  input  logic [RW-1:0]     dst_base_i,
  input  logic [1:0]        ew_i,
  input  logic              reverse_i,
  input  logic              sat_i,
  input  logic              ffirst_i,
  output logic              issue_valid_o,
  input  logic              issue_ready_i,
  output logic [IW-1:0]     src_idx_o,
  output logic [IW-1:0]     dst_idx_o,
  output logic [RW-1:0]     src_reg_o,
  output logic [RW-1:0]     dst_reg_o,
  output logic [1:0]        ew_o,
  output logic              sat_o,
  input  logic              cond_ok_i,
  output logic              done_o,
  output logic [CW-1:0]     done_vl_o
);
  seq_state_e        st_q;
  logic [MAX_VL-1:0] src_left_q, dst_left_q;
  logic [MAX_VL-1:0] src_init, dst_init;
  logic [CW-1:0]     cnt_q;
  logic              stop_q;
  elem_width_e       ew_q;
  logic              sat_q, rev_q, ff_q;
  logic [RW-1:0]     src_base_q, dst_base_q;
  logic              src_found, dst_found, both_found, hs, fail_hs;
  logic [IW-1:0]     src_idx, dst_idx;

  vseq_mask_prep #(.MAX_VL(MAX_VL), .REG_COUNT(REG_COUNT)) u_src_prep (
    .int_mask_i(src_mask_int_i), .cr_mask_i(src_mask_cr_i), .sel_i(src_mask_sel_i),
    .vl_i(vl_i), .base_i(src_base_i), .live_o(src_init)
  );
  vseq_mask_prep #(.MAX_VL(MAX_VL), .REG_COUNT(REG_COUNT)) u_dst_prep (
    .int_mask_i(dst_mask_int_i), .cr_mask_i(dst_mask_cr_i), .sel_i(dst_mask_sel_i),
    .vl_i(vl_i), .base_i(dst_base_i), .live_o(dst_init)
  );
  vseq_pick #(.MAX_VL(MAX_VL)) u_src_pick (
    .live_i(src_left_q), .rev_i(rev_q), .found_o(src_found), .idx_o(src_idx)
  );
  vseq_pick #(.MAX_VL(MAX_VL)) u_dst_pick (
    .live_i(dst_left_q), .rev_i(rev_q), .found_o(dst_found), .idx_o(dst_idx)
  );

  assign both_found    = src_found & dst_found;
  assign issue_valid_o = (st_q == ST_RUN) & both_found & ~stop_q;
  assign done_o        = (st_q == ST_RUN) & (~both_found | stop_q);
  assign hs            = issue_valid_o & issue_ready_i;
  assign fail_hs       = hs & ff_q & ~cond_ok_i;

  assign src_idx_o = src_idx;
  assign dst_idx_o = dst_idx;
  assign src_reg_o = src_base_q + RW'(src_idx);
  assign dst_reg_o = dst_base_q + RW'(dst_idx);
  assign ew_o      = ew_q;
  assign sat_o     = sat_q;
  assign done_vl_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      src_left_q <= '0;
      dst_left_q <= '0;
      cnt_q      <= '0;
      stop_q     <= 1'b0;
      ew_q       <= EW_8;
      sat_q      <= 1'b0;
      rev_q      <= 1'b0;
      ff_q       <= 1'b0;
      src_base_q <= '0;
      dst_base_q <= '0;
    end else if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_q       <= ST_RUN;
        src_left_q <= src_init;
        dst_left_q <= dst_init;
        cnt_q      <= '0;
        stop_q     <= 1'b0;
        ew_q       <= elem_width_e'(ew_i);
        sat_q      <= sat_i;
        rev_q      <= reverse_i;
        ff_q       <= ffirst_i;
        src_base_q <= src_base_i;
        dst_base_q <= dst_base_i;
      end
    end else begin
      if (done_o) begin
        st_q   <= ST_IDLE;
        stop_q <= 1'b0;
      end else if (fail_hs) begin
        stop_q <= 1'b1;
      end else if (hs) begin
        src_left_q <= src_left_q & ~(MAX_VL'(1) << src_idx);
        dst_left_q <= dst_left_q & ~(MAX_VL'(1) << dst_idx);
        cnt_q      <= cnt_q + CW'(1);
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !issue_ready_i) |=>
      (issue_valid_o && $stable(src_idx_o) && $stable(dst_idx_o) && $stable(src_reg_o)
       && $stable(dst_reg_o) && $stable(ew_o) && $stable(sat_o)));

  assert_fwd_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && !rev_q && !fail_hs) |=>
      (!issue_valid_o || (src_idx_o > $past(src_idx_o) && dst_idx_o > $past(dst_idx_o))));

  assert_rev_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && rev_q && !fail_hs) |=>
      (!issue_valid_o || (src_idx_o < $past(src_idx_o) && dst_idx_o < $past(dst_idx_o))));

  assert_fail_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_hs |=> (done_o && !issue_valid_o && $stable(done_vl_o)));

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (src_reg_o >= src_base_q && dst_reg_o >= dst_base_q));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !issue_valid_o);
endmodule

// File: tb/vec_elem_seq_tb.sv
module vec_elem_seq_tb;
  localparam int N       = 16;
  localparam int REGS    = 128;
  localparam int CLK_PER = 10;
  localparam int CW      = $clog2(N + 1);
  localparam int IW      = $clog2(N);
  localparam int RW      = $clog2(REGS);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] vl_i = '0;
  logic [N-1:0]  src_mask_int_i = '0, src_mask_cr_i = '0, dst_mask_int_i = '0, dst_mask_cr_i = '0;
  logic          src_mask_sel_i = 1'b0, dst_mask_sel_i = 1'b0;
  logic [RW-1:0] src_base_i = '0, dst_base_i = '0;
  logic [1:0]    ew_i = '0;
  logic          reverse_i = 1'b0, sat_i = 1'b0, ffirst_i = 1'b0;
  logic          issue_valid_o, issue_ready_i = 1'b0, cond_ok_i = 1'b1;
  logic [IW-1:0] src_idx_o, dst_idx_o;
  logic [RW-1:0] src_reg_o, dst_reg_o;
  logic [1:0]    ew_o;
  logic          sat_o, done_o;
  logic [CW-1:0] done_vl_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  vec_elem_seq #(.MAX_VL(N), .REG_COUNT(REGS)) u_dut (
    .clk_i, .rst_ni, .start_i, .vl_i,
    .src_mask_int_i, .src_mask_cr_i, .src_mask_sel_i,
    .dst_mask_int_i, .dst_mask_cr_i, .dst_mask_sel_i,
    .src_base_i, .dst_base_i, .ew_i, .reverse_i, .sat_i, .ffirst_i,
    .issue_valid_o, .issue_ready_i, .src_idx_o, .dst_idx_o, .src_reg_o, .dst_reg_o,
    .ew_o, .sat_o, .cond_ok_i, .done_o, .done_vl_o
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Builds the expected live-element order for one side.
  task automatic build_list(input logic [N-1:0] m, input int vl, input int base, input bit rev,
                            output int lst[N], output int cnt);
    cnt = 0;
    for (int j = 0; j < N; j++) lst[j] = 0;
    for (int j = 0; j < N; j++) begin
      int e;
      e = rev ? (N - 1 - j) : j;
      if (m[e] && e < vl && base + e < REGS) begin
        lst[cnt] = e;
        cnt++;
      end
    end
  endtask

  task automatic run_case(input string req, input int vl, input logic [N-1:0] sm, input logic [N-1:0] dm,
                          input bit ssel, input bit dsel, input int sb, input int db,
                          input bit rev, input bit sat, input bit ff, input int fail_at,
                          input logic [1:0] ew, input logic [15:0] rdy_pat);
    int sl[N], dl[N];
    int ns, nd, n, k, cyc, exp_vl, exp_hs;
    bit got_done;
    build_list(sm, vl, sb, rev, sl, ns);
    build_list(dm, vl, db, rev, dl, nd);
    n = (ns < nd) ? ns : nd;
    exp_vl = n;
    exp_hs = n;
    if (ff && fail_at >= 0 && fail_at < n) begin
      exp_vl = fail_at;
      exp_hs = fail_at + 1;
    end
    @(negedge clk_i);
    vl_i = CW'(vl);
    src_mask_int_i = ssel ? ~sm : sm;  src_mask_cr_i = ssel ? sm : ~sm;
    dst_mask_int_i = dsel ? ~dm : dm;  dst_mask_cr_i = dsel ? dm : ~dm;
    src_mask_sel_i = ssel; dst_mask_sel_i = dsel;
    src_base_i = RW'(sb); dst_base_i = RW'(db);
    reverse_i = rev; sat_i = sat; ffirst_i = ff; ew_i = ew;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    k = 0; got_done = 0;
    for (cyc = 0; cyc < 300; cyc++) begin
      issue_ready_i = rdy_pat[cyc % 16];
      cond_ok_i = !(ff && k == fail_at);
      #1;
      if (done_o) begin
        got_done = 1;
        chk(issue_valid_o == 1'b0, "R11", "valid during done", int'(issue_valid_o), 0);
        break;
      end
      if (issue_valid_o && issue_ready_i) begin
        if (k < n) begin
          chk(int'(src_idx_o) == sl[k], req, "src index", int'(src_idx_o), sl[k]);
          chk(int'(dst_idx_o) == dl[k], req, "dst index", int'(dst_idx_o), dl[k]);
          chk(int'(src_reg_o) == sb + sl[k], "R8", "src reg", int'(src_reg_o), sb + sl[k]);
          chk(int'(dst_reg_o) == db + dl[k], "R8", "dst reg", int'(dst_reg_o), db + dl[k]);
          chk(ew_o == ew, "R5", "width code", int'(ew_o), int'(ew));
          chk(sat_o == sat, "R6", "sat flag", int'(sat_o), int'(sat));
        end
        k++;
      end
      @(negedge clk_i);
    end
    chk(got_done, req, "done seen", int'(got_done), 1);
    if (vl == 0 || n == 0) chk(cyc == 0, "R9", "done latency", cyc, 0);
    chk(k == exp_hs, req, "handshake count", k, exp_hs);
    chk(int'(done_vl_o) == exp_vl, "R11", "done_vl", int'(done_vl_o), exp_vl);
    @(negedge clk_i);
    #1;
    chk(done_o == 1'b0, "R11", "done width", int'(done_o), 0);
    chk(issue_valid_o == 1'b0, "R11", "idle valid", int'(issue_valid_o), 0);
    issue_ready_i = 1'b0;
    cond_ok_i = 1'b1;
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(issue_valid_o == 1'b0, "R11", "reset valid", int'(issue_valid_o), 0);
    chk(done_o == 1'b0, "R11", "reset done", int'(done_o), 0);
    rst_ni = 1'b1;
    // R1: forward, all elements live, always ready
    run_case("R1", 5, 16'hFFFF, 16'hFFFF, 0, 0, 0, 32, 0, 0, 0, -1, 2'd2, 16'hFFFF);
    // R2 and R10: independent masks, gappy ready
    run_case("R2", 8, 16'h00A6, 16'h0059, 0, 1, 10, 40, 0, 0, 0, -1, 2'd1, 16'b0110_1101_0011_1010);
    // R3: reverse traversal
    run_case("R3", 7, 16'h006B, 16'h0077, 1, 0, 0, 0, 1, 1, 0, -1, 2'd0, 16'b1011_0111_1101_1110);
    // R4: fail-first stops at third accepted element
    run_case("R4", 9, 16'h01FF, 16'h01F7, 0, 0, 4, 8, 0, 0, 1, 2, 2'd3, 16'hFFFF);
    // R4: fail-first on the very first element
    run_case("R4", 6, 16'h003F, 16'h003F, 0, 0, 0, 0, 1, 0, 1, 0, 2'd0, 16'b1010_1010_1010_1010);
    // R4: fail-first enabled but the condition never fails
    run_case("R4", 6, 16'h002D, 16'h003F, 1, 1, 0, 0, 0, 1, 1, -1, 2'd2, 16'hFFFF);
    // R9: zero vector length
    run_case("R9", 0, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, -1, 2'd0, 16'hFFFF);
    // R9: empty source mask
    run_case("R9", 10, 16'h0000, 16'hFFFF, 1, 0, 0, 0, 0, 0, 0, -1, 2'd0, 16'hFFFF);
    // R7: both sides take condition-field images
    run_case("R7", 16, 16'hC3A5, 16'h5AF0, 1, 1, 20, 60, 0, 1, 0, -1, 2'd3, 16'b1110_1110_1110_1110);
    // R8: source side runs into the top of the register file
    run_case("R8", 8, 16'h00FF, 16'h00FF, 0, 0, 124, 0, 0, 0, 0, -1, 2'd1, 16'hFFFF);
    // R8: reverse with high base skips elements past the file
    run_case("R8", 12, 16'h0FFF, 16'h0FFF, 0, 0, 0, 119, 1, 0, 0, -1, 2'd2, 16'hFFFF);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule